// File: doc/BRIEF.md
# Snake-Scan 4x4 SAD Array

This block performs exhaustive block matching for one current block against a square search window. A current block of `BLK`x`BLK` 8-bit pixels is first written row by row. A reference stream then supplies pixels of the search window. Every candidate position is visited once. For each candidate the block reports the sum of absolute differences (SAD) of each `SUB`x`SUB` subblock of the current block, together with the candidate's motion vector.

Candidate positions follow a snake over the window. The scan runs down the first column of positions, steps one position right, runs up the next column, and repeats. Because of this order, only one row or one column of reference pixels separates two consecutive candidates. The candidate block is kept in a shift register that can move in three directions. Each step therefore takes a single reference beat. A band of `SUB`x`BLK` absolute-difference units (64 with the defaults) covers the candidate in `BLK/SUB` cycles.

All three data paths use valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. `cur_ready` and `ref_ready` depend only on the block's state, never on the matching valid signal. Once `res_valid` is raised, it stays high with its payload unchanged until `res_ready` is sampled high. While a result is pending, no reference beat is accepted. `done` is a plain one-cycle pulse.

Top module: `me_sad_array`

## Requirements
- R1: After reset, `cur_ready`=1, `ref_ready`=0, `res_valid`=0 and `done`=0. The current block is taken as `BLK` beats on `cur_row`, top row first, with column c at bits [c*8+:8]. `cur_ready` is low at all other times, and data offered on `cur_row` while `cur_ready` is low has no effect on any result.
- R2: After the current block is loaded, the block accepts exactly `BLK` reference beats before its first result. These are the rows of the top-left candidate, top row first, each in the `cur_row` layout.
- R3: Candidate (x,y), where x and y are column and row offsets in the window from 0 to RANGE-1, starts at (0,0). When x is even, y increases until it reaches RANGE-1. When x is odd, y decreases until it reaches 0. At the end of a column, x increases by one. Consecutive results therefore differ by exactly one in exactly one coordinate.
- R4: Between two results of the same scan, exactly one reference beat is accepted. For a downward step, the beat is the new bottom row of the candidate. For an upward step, it is the new top row. For a rightward step, it is the new right column, with the top pixel at bits [7:0].
- R5: `res_sad` holds `(BLK/SUB)^2` fields of 12 bits. Field k = by*(BLK/SUB)+bx sits at bits [k*12+:12] and equals the sum of |cur-ref| over subblock row by and subblock column bx. The largest value is 4080.
- R6: `res_mv_x` = x - RANGE/2 and `res_mv_y` = y - RANGE/2, both two's complement on log2(RANGE) bits. The first result of a scan is (-RANGE/2, -RANGE/2).
- R7: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_sad` and both vector outputs stay stable. `ref_ready` is low whenever `res_valid` is high.
- R8: `done` is high for exactly one cycle, the cycle after the final result is accepted. `cur_ready` is high from that cycle on, ready for the next block.
- R9: Each scan yields exactly RANGE*RANGE results, one per candidate position, before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_valid | input | 1 | Current-block row offered |
| cur_ready | output | 1 | Current-block row accepted |
| cur_row | input | BLK*8 | One row of the current block |
| ref_valid | input | 1 | Reference beat offered |
| ref_ready | output | 1 | Reference beat accepted |
| ref_line | input | BLK*8 | One reference row or column |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_sad | output | (BLK/SUB)^2*12 | Subblock SADs of the candidate |
| res_mv_x | output | log2(RANGE) | Signed horizontal offset |
| res_mv_y | output | log2(RANGE) | Signed vertical offset |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
A corrupted pixel in the candidate shift register shows up as wrong SAD fields in the next result. That result appears `BLK/SUB`+1 cycles after the reference beat that should have set the pixel. The error then travels with the window, so later results stay wrong until the row or column that holds it leaves the window. A wrong scan counter or shift direction shows as a motion-vector step that is not a unit step, or as a wrong SAD, no later than the next result. A control fault shows as a missing `done` pulse, or as the wrong number of results before it.

// File: rtl/me_sad_pkg.sv
package me_sad_pkg;
  typedef enum logic [1:0] {
    SH_DOWN  = 2'd0,  // new row enters at the bottom
    SH_UP    = 2'd1,  // new row enters at the top
    SH_RIGHT = 2'd2   // new column enters at the right
  } shift_dir_e;

  typedef enum logic [2:0] {
    ST_CUR  = 3'd0,
    ST_FILL = 3'd1,
    ST_CALC = 3'd2,
    ST_OUT  = 3'd3,
    ST_STEP = 3'd4
  } scan_st_e;
endpackage

// File: rtl/me_scan_ctrl.sv
module me_scan_ctrl
  import me_sad_pkg::*;
#(
  parameter int BLK   = 16,
  parameter int NB    = 4,
  parameter int RANGE = 32,
  localparam int CW   = $clog2(BLK),
  localparam int RW   = $clog2(RANGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cur_valid,
  output logic          cur_ready,
  input  logic          ref_valid,
  output logic          ref_ready,
  output shift_dir_e    shift_dir,
  output logic          calc_en,
  output logic [CW-1:0] idx,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [RW-1:0] pos_x,
  output logic [RW-1:0] pos_y,
  output logic          done
);
  scan_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] x_q, y_q;
  shift_dir_e    dir_q, next_dir;
  logic          done_q, is_last;

  // Snake: even columns run downward, odd columns upward.
  always_comb begin
    is_last = (x_q == RW'(RANGE - 1)) &&
              (x_q[0] ? (y_q == '0) : (y_q == RW'(RANGE - 1)));
    if (!x_q[0]) next_dir = (y_q != RW'(RANGE - 1)) ? SH_DOWN : SH_RIGHT;
    else         next_dir = (y_q != '0) ? SH_UP : SH_RIGHT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_CUR;
      cnt_q  <= '0;
      x_q    <= '0;
      y_q    <= '0;
      dir_q  <= SH_DOWN;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_CUR: if (cur_valid) begin
          if (cnt_q == CW'(BLK - 1)) begin
            cnt_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
            st_q  <= ST_FILL;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_FILL: if (ref_valid) begin
          if (cnt_q == CW'(BLK - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_CALC;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_CALC: begin
          if (cnt_q == CW'(NB - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_OUT;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_OUT: if (res_ready) begin
          if (is_last) begin
            done_q <= 1'b1;
            st_q   <= ST_CUR;
          end else begin
            dir_q <= next_dir;
            unique case (next_dir)
              SH_DOWN: y_q <= y_q + RW'(1);
              SH_UP:   y_q <= y_q - RW'(1);
              default: x_q <= x_q + RW'(1);
            endcase
            st_q <= ST_STEP;
          end
        end
        ST_STEP: if (ref_valid) st_q <= ST_CALC;
        default: st_q <= ST_CUR;
      endcase
    end
  end

  assign cur_ready = (st_q == ST_CUR);
  assign ref_ready = (st_q == ST_FILL) || (st_q == ST_STEP);
  assign shift_dir = (st_q == ST_FILL) ? SH_DOWN : dir_q;
  assign calc_en   = (st_q == ST_CALC);
  assign idx       = cnt_q;
  assign res_valid = (st_q == ST_OUT);
  assign pos_x     = x_q;
  assign pos_y     = y_q;
  assign done      = done_q;
endmodule

// File: rtl/me_ref_window.sv
module me_ref_window
  import me_sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  localparam int LINE_W = BLK * PIX_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  shift_dir_e                shift_dir,
  input  logic [LINE_W-1:0]         line_i,
  output logic [BLK*LINE_W-1:0]     win_o
);
  logic [LINE_W-1:0] rows_q [BLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < BLK; r++) rows_q[r] <= '0;
    end else if (shift_en) begin
      unique case (shift_dir)
        SH_DOWN: begin
          for (int r = 0; r < BLK - 1; r++) rows_q[r] <= rows_q[r+1];
          rows_q[BLK-1] <= line_i;
        end
        SH_UP: begin
          for (int r = 1; r < BLK; r++) rows_q[r] <= rows_q[r-1];
          rows_q[0] <= line_i;
        end
        default: begin
          // Every pixel moves one column left; the new column enters at the right.
          for (int r = 0; r < BLK; r++)
            rows_q[r] <= {line_i[r*PIX_W +: PIX_W], rows_q[r][LINE_W-1:PIX_W]};
        end
      endcase
    end
  end

  for (genvar r = 0; r < BLK; r++) begin : g_flat
    assign win_o[r*LINE_W +: LINE_W] = rows_q[r];
  end
endmodule

// File: rtl/me_sad_band.sv
module me_sad_band #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  parameter int SUB   = 4,
  parameter int SAD_W = 12,
  localparam int NB    = BLK / SUB,
  localparam int NPE   = SUB * BLK,
  localparam int BAND_W = NPE * PIX_W
) (
  input  logic [BAND_W-1:0]   cur_band,
  input  logic [BAND_W-1:0]   ref_band,
  output logic [NB*SAD_W-1:0] part_o
);
  logic [PIX_W-1:0] diff [NPE];

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    logic [PIX_W-1:0] a, b;
    assign a       = cur_band[p*PIX_W +: PIX_W];
    assign b       = ref_band[p*PIX_W +: PIX_W];
    assign diff[p] = (a > b) ? (a - b) : (b - a);
  end

  for (genvar j = 0; j < NB; j++) begin : g_sum
    logic [SAD_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int r = 0; r < SUB; r++)
        for (int c = 0; c < SUB; c++)
          acc = acc + SAD_W'(diff[r*BLK + j*SUB + c]);
    end
    assign part_o[j*SAD_W +: SAD_W] = acc;
  end
endmodule

// File: rtl/me_sad_array.sv
module me_sad_array
  import me_sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  parameter int SUB   = 4,
  parameter int RANGE = 32,
  localparam int NB     = BLK / SUB,
  localparam int NSUB   = NB * NB,
  localparam int SAD_W  = $clog2(SUB * SUB * ((1 << PIX_W) - 1) + 1),
  localparam int MV_W   = $clog2(RANGE),
  localparam int LINE_W = BLK * PIX_W,
  localparam int CW     = $clog2(BLK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cur_valid,
  output logic                    cur_ready,
  input  logic [LINE_W-1:0]       cur_row,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic [LINE_W-1:0]       ref_line,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [NSUB*SAD_W-1:0]   res_sad,
  output logic signed [MV_W-1:0]  res_mv_x,
  output logic signed [MV_W-1:0]  res_mv_y,
  output logic                    done
);
  shift_dir_e              shift_dir;
  logic                    calc_en;
  logic [CW-1:0]           idx;
  logic [MV_W-1:0]         pos_x, pos_y;
  logic [LINE_W-1:0]       cur_q [BLK];
  logic [BLK*LINE_W-1:0]   win;
  logic [SUB*LINE_W-1:0]   cur_band, ref_band;
  logic [NB*SAD_W-1:0]     part;
  logic [SAD_W-1:0]        sad_q [NSUB];

  me_scan_ctrl #(.BLK(BLK), .NB(NB), .RANGE(RANGE)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cur_valid(cur_valid), .cur_ready(cur_ready),
    .ref_valid(ref_valid), .ref_ready(ref_ready),
    .shift_dir(shift_dir), .calc_en(calc_en), .idx(idx),
    .res_valid(res_valid), .res_ready(res_ready),
    .pos_x(pos_x), .pos_y(pos_y), .done(done)
  );

  me_ref_window #(.PIX_W(PIX_W), .BLK(BLK)) win_i (
    .clk(clk), .rst_n(rst_n),
    .shift_en(ref_valid && ref_ready), .shift_dir(shift_dir),
    .line_i(ref_line), .win_o(win)
  );

  // Current block store, written one row per accepted beat.
  always_ff @(posedge clk) begin
    if (cur_valid && cur_ready) cur_q[idx] <= cur_row;
  end

  // Select the band of SUB rows handled in this cycle.
  always_comb begin
    for (int r = 0; r < SUB; r++) begin
      cur_band[r*LINE_W +: LINE_W] = cur_q[int'(idx)*SUB + r];
      ref_band[r*LINE_W +: LINE_W] = win[(int'(idx)*SUB + r)*LINE_W +: LINE_W];
    end
  end

  me_sad_band #(.PIX_W(PIX_W), .BLK(BLK), .SUB(SUB), .SAD_W(SAD_W)) band_i (
    .cur_band(cur_band), .ref_band(ref_band), .part_o(part)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NSUB; k++) sad_q[k] <= '0;
    end else if (calc_en) begin
      for (int j = 0; j < NB; j++)
        sad_q[int'(idx)*NB + j] <= part[j*SAD_W +: SAD_W];
    end
  end

  for (genvar k = 0; k < NSUB; k++) begin : g_pack
    assign res_sad[k*SAD_W +: SAD_W] = sad_q[k];
  end

  assign res_mv_x = $signed(pos_x - MV_W'(RANGE / 2));
  assign res_mv_y = $signed(pos_y - MV_W'(RANGE / 2));
endmodule

// File: rtl/me_sad_array_chk.sv
module me_sad_array_chk #(
  parameter int BLK    = 16,
  parameter int SAD_BITS = 192,
  parameter int MV_W   = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cur_valid,
  input logic                   cur_ready,
  input logic                   ref_valid,
  input logic                   ref_ready,
  input logic                   res_valid,
  input logic                   res_ready,
  input logic [SAD_BITS-1:0]    res_sad,
  input logic signed [MV_W-1:0] res_mv_x,
  input logic signed [MV_W-1:0] res_mv_y,
  input logic                   done
);
  logic [15:0]           beats_q;
  logic                  first_q, have_prev_q, step_ok;
  logic signed [MV_W-1:0] px_q, py_q;
  logic signed [MV_W:0]  dx, dy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats_q     <= '0;
      first_q     <= 1'b0;
      have_prev_q <= 1'b0;
      px_q        <= '0;
      py_q        <= '0;
    end else begin
      if (cur_valid && cur_ready) begin
        first_q     <= 1'b1;
        have_prev_q <= 1'b0;
      end
      if (res_valid && res_ready) begin
        beats_q     <= '0;
        first_q     <= 1'b0;
        have_prev_q <= 1'b1;
        px_q        <= res_mv_x;
        py_q        <= res_mv_y;
      end else if (ref_valid && ref_ready) begin
        beats_q <= beats_q + 16'd1;
      end
    end
  end

  always_comb begin
    dx = (MV_W+1)'(res_mv_x) - (MV_W+1)'(px_q);
    dy = (MV_W+1)'(res_mv_y) - (MV_W+1)'(py_q);
    step_ok = ((dx == 0) && ((dy == 1) || (dy == -1))) ||
              ((dy == 0) && ((dx == 1) || (dx == -1)));
  end

  AST_FILL_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && first_q) |-> (beats_q == 16'(BLK))); // R2
  AST_ONE_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !first_q) |-> (beats_q == 16'd1)); // R4
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(res_valid) && have_prev_q) |-> step_ok); // R3
  AST_FIRST_MV: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !have_prev_q) |-> (res_mv_x == {1'b1, {(MV_W-1){1'b0}}} &&
                                     res_mv_y == {1'b1, {(MV_W-1){1'b0}}})); // R6
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_sad) &&
                                   $stable(res_mv_x) && $stable(res_mv_y))); // R7
  AST_NO_REF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !ref_ready); // R7
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid && res_ready)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cur_ready)); // R8
endmodule

bind me_sad_array me_sad_array_chk #(
  .BLK(BLK), .SAD_BITS(NSUB * SAD_W), .MV_W(MV_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cur_valid(cur_valid), .cur_ready(cur_ready),
  .ref_valid(ref_valid), .ref_ready(ref_ready),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_sad(res_sad), .res_mv_x(res_mv_x), .res_mv_y(res_mv_y),
  .done(done)
);

// File: tb/me_sad_array_tb_top.sv
module me_sad_array_tb_top;
  localparam int PIX_W  = 8;
  localparam int BLK    = 8;
  localparam int SUB    = 4;
  localparam int RANGE  = 4;
  localparam int NB     = BLK / SUB;
  localparam int NSUB   = NB * NB;
  localparam int SAD_W  = 12;
  localparam int MV_W   = 2;
  localparam int LINE_W = BLK * PIX_W;
  localparam int WN     = BLK + RANGE - 1;
  localparam int NCAND  = RANGE * RANGE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cur_valid = 1'b0, ref_valid = 1'b0, res_ready = 1'b0;
  logic [LINE_W-1:0] cur_row = '0, ref_line = '0;
  logic cur_ready, ref_ready, res_valid, done;
  logic [NSUB*SAD_W-1:0] res_sad;
  logic signed [MV_W-1:0] res_mv_x, res_mv_y;

  int cur_px [BLK][BLK];
  int win_px [WN][WN];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  me_sad_array #(.PIX_W(PIX_W), .BLK(BLK), .SUB(SUB), .RANGE(RANGE)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cur_valid(cur_valid), .cur_ready(cur_ready), .cur_row(cur_row),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_line(ref_line),
    .res_valid(res_valid), .res_ready(res_ready), .res_sad(res_sad),
    .res_mv_x(res_mv_x), .res_mv_y(res_mv_y), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Snake order from the requirement: even columns down, odd columns up.
  function automatic int px_of(input int n);
    return n / RANGE;
  endfunction
  function automatic int py_of(input int n);
    int col = n / RANGE;
    int p = n % RANGE;
    return (col % 2 == 0) ? p : RANGE - 1 - p;
  endfunction

  function automatic longint exp_sad(input int x, input int y);
    longint v = 0;
    for (int k = 0; k < NSUB; k++) begin
      int by = k / NB, bx = k % NB, s = 0;
      for (int r = 0; r < SUB; r++)
        for (int c = 0; c < SUB; c++) begin
          int a = cur_px[by*SUB+r][bx*SUB+c];
          int b = win_px[y+by*SUB+r][x+bx*SUB+c];
          s += (a > b) ? a - b : b - a;
        end
      v |= longint'(s) << (k * SAD_W);
    end
    return v;
  endfunction

  task automatic send_ref(input logic [LINE_W-1:0] line);
    bit ok;
    ref_valid = 1'b1;
    ref_line  = line;
    do begin
      ok = ref_ready;
      @(negedge clk);
    end while (!ok);
    ref_valid = 1'b0;
  endtask

  task automatic driver();
    logic [LINE_W-1:0] line;
    for (int r = 0; r < BLK; r++) begin
      bit ok;
      for (int c = 0; c < BLK; c++) cur_row[c*PIX_W +: PIX_W] = PIX_W'(cur_px[r][c]);
      cur_valid = 1'b1;
      do begin
        ok = cur_ready;
        @(negedge clk);
      end while (!ok);
    end
    // Junk held on the current-block port while it is not ready (R1).
    cur_row = '1 ^ cur_row;
    for (int n = 0; n < NCAND; n++) begin
      int x = px_of(n), y = py_of(n);
      if (n == 0) begin
        for (int r = 0; r < BLK; r++) begin
          for (int c = 0; c < BLK; c++) line[c*PIX_W +: PIX_W] = PIX_W'(win_px[r][c]);
          send_ref(line);
        end
      end else begin
        if (x != px_of(n-1))
          for (int i = 0; i < BLK; i++) line[i*PIX_W +: PIX_W] = PIX_W'(win_px[y+i][x+BLK-1]);
        else if (y > py_of(n-1))
          for (int c = 0; c < BLK; c++) line[c*PIX_W +: PIX_W] = PIX_W'(win_px[y+BLK-1][x+c]);
        else
          for (int c = 0; c < BLK; c++) line[c*PIX_W +: PIX_W] = PIX_W'(win_px[y][x+c]);
        repeat ($urandom % 3) @(negedge clk);
        send_ref(line);
      end
    end
    cur_valid = 1'b0;
  endtask

  task automatic monitor();
    int got = 0;
    bit stalled = 1'b0;
    logic [NSUB*SAD_W-1:0] h_sad = '0;
    logic [2*MV_W-1:0] h_mv = '0;
    while (got < NCAND) begin
      res_ready = (($urandom % 4) != 0);
      if (stalled) begin
        check(res_valid === 1'b1 && res_sad === h_sad && {res_mv_x, res_mv_y} === h_mv,
              "R7", "payload held under back-pressure", longint'(res_sad), longint'(h_sad));
        check(ref_ready === 1'b0, "R7", "ref_ready while result pending", ref_ready, 0);
      end
      stalled = 1'b0;
      if (res_valid) begin
        if (res_ready) begin
          int x = px_of(got), y = py_of(got);
          check(int'(res_mv_x) == x - RANGE/2, "R6", "mv_x (R3 order)", res_mv_x, x - RANGE/2);
          check(int'(res_mv_y) == y - RANGE/2, "R6", "mv_y (R3 order)", res_mv_y, y - RANGE/2);
          check(res_sad === exp_sad(x, y), "R5", "subblock SADs (R4 line reuse)",
                longint'(res_sad), exp_sad(x, y));
          check(cur_ready === 1'b0 && done === 1'b0, "R1", "idle cur_ready/done mid-scan",
                {cur_ready, done}, 0);
          got++;
        end else begin
          stalled = 1'b1;
          h_sad = res_sad;
          h_mv = {res_mv_x, res_mv_y};
        end
      end
      @(negedge clk);
    end
    res_ready = 1'b0;
    check(done === 1'b1, "R8", "done after final result", done, 1);
    check(got == NCAND, "R9", "result count", got, NCAND);
    @(negedge clk);
    check(done === 1'b0 && cur_ready === 1'b1, "R8", "done single cycle, cur_ready back",
          {done, cur_ready}, 1);
    check(res_valid === 1'b0, "R9", "no extra result", res_valid, 0);
  endtask

  task automatic run_frame();
    fork
      driver();
      monitor();
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cur_ready === 1'b1, "R1", "reset cur_ready", cur_ready, 1);
    check(ref_ready === 1'b0, "R1", "reset ref_ready", ref_ready, 0);
    check(res_valid === 1'b0, "R1", "reset res_valid", res_valid, 0);
    check(done === 1'b0, "R8", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Frame 1: random pixels.
    for (int r = 0; r < BLK; r++) for (int c = 0; c < BLK; c++) cur_px[r][c] = $urandom % 256;
    for (int r = 0; r < WN; r++) for (int c = 0; c < WN; c++) win_px[r][c] = $urandom % 256;
    run_frame();
    // Frame 2: extreme difference, every field 4080.
    for (int r = 0; r < BLK; r++) for (int c = 0; c < BLK; c++) cur_px[r][c] = 255;
    for (int r = 0; r < WN; r++) for (int c = 0; c < WN; c++) win_px[r][c] = 0;
    run_frame();
    // Frame 3: exact match at window offset (1,2), zero SAD there.
    for (int r = 0; r < WN; r++) for (int c = 0; c < WN; c++) win_px[r][c] = $urandom % 256;
    for (int r = 0; r < BLK; r++) for (int c = 0; c < BLK; c++) cur_px[r][c] = win_px[r+2][c+1];
    run_frame();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule